// File: doc/BRIEF.md
# Synthesizer Holdover and Lock Supervisor

This block watches the phase detector of a frequency synthesizer loop and decides when the loop must be frozen in holdover. A digital lock detector counts consecutive phase-detector cycles whose edges fall inside the lock window. A three-state sequencer (reacquire, locked, holdover) uses that lock indication, an optional lock-pin comparator level, and the reference-switch status of the selected reference. While holdover is active, the block asks the charge pump to go tri-state, so the loop filter holds the last control voltage.

Holdover can be requested by software through an external request. It can also be engaged automatically when lock is lost. Once holdover ends, the sequencer passes through reacquire and re-arms only after lock is declared again and the lock pin reads high. If lock is lost while a reference switchover is in progress, the holdover lasts only until the next reference edge. No data stream passes through the block. Every pin is a plain level or a one-cycle strobe, sampled on the rising clock edge, so there is no valid/ready handshake and no back-pressure. Reset is synchronous and active low.

Top module: `holdover_ctrl`

## Requirements
- R1: After reset, `lock_ok`, `hov_active` and `cp_tristate` are all low, and the sequencer is in reacquire.
- R2: `lock_ok` rises on the clock edge that samples the Nth consecutive `pfd_stb` with `pfd_in_win`=1. N is set by `ld_cnt_sel`: 0→5, 1→16, 2→64, 3→255. Between strobes, `lock_ok` holds its value.
- R3: A `pfd_stb` with `pfd_in_win`=0 clears the count and drives `lock_ok` low one cycle later.
- R4: While `dld_off`=1, the count is held at zero and `lock_ok` is low. Automatic holdover never engages.
- R5: With `lkpin_cmp_en`=1, reacquire moves to locked only while `lkpin_level`=1. With `lkpin_cmp_en`=0, the pin is treated as high.
- R6: With `hov_en`=0, no holdover is entered. If holdover is active when `hov_en` falls, it ends one cycle later.
- R7: With `hov_ext_mode`=1, the locked state enters holdover when `hov_ext_req`=1, and holdover ends one cycle after `hov_ext_req` falls.
- R8: With `hov_ext_mode`=0, the locked state enters holdover on the edge after `lock_ok` falls.
- R9: Holdover is entered only from the locked state. After holdover ends, no new holdover occurs until lock is declared and the pin reads high again.
- R10: An automatic holdover that began while `sw_busy`=1 ends at the next `ref_edge_stb`. Any other automatic holdover ends only at a `ref_edge_stb` sampled with `sw_busy`=0.
- R11: `cp_tristate` is high exactly while `hov_active` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfd_stb | input | 1 | One-cycle strobe per phase-detector cycle |
| pfd_in_win | input | 1 | Edges of this phase-detector cycle were inside the lock window |
| ld_cnt_sel | input | 2 | Lock count select (5/16/64/255) |
| dld_off | input | 1 | Disables the digital lock detector |
| lkpin_level | input | 1 | Lock-pin comparator level |
| lkpin_cmp_en | input | 1 | Use the comparator level; when 0 the pin reads high |
| hov_en | input | 1 | Master holdover enable |
| hov_ext_mode | input | 1 | 1: external request drives holdover; 0: automatic |
| hov_ext_req | input | 1 | External holdover request |
| sw_busy | input | 1 | Reference switchover in progress |
| ref_edge_stb | input | 1 | Edge seen on the selected reference |
| lock_ok | output | 1 | Digital lock indication |
| hov_active | output | 1 | Holdover in effect |
| cp_tristate | output | 1 | Charge-pump tri-state request |

## Verification
The hardest situation to reach from the ports is a lock loss that falls inside a switchover window. Both lock and the locked state must already be established, and then `sw_busy` must be raised before a bad phase-detector cycle arrives. The short holdover is then distinguishable only because a reference edge with `sw_busy` still high ends it. A directed sequence builds that order on purpose. It also builds the opposite case, where an edge during switchover must not end an ordinary holdover. Long random runs with a fixed seed then mix mode changes, pin drops and enable toggles. Each cycle they are checked against a cycle model written from the requirements.

// File: rtl/hov_pkg.sv
package hov_pkg;
  typedef enum logic [1:0] {
    HS_REACQ  = 2'd0,
    HS_LOCKED = 2'd1,
    HS_HOLD   = 2'd2
  } hov_state_e;
endpackage

// File: rtl/hov_lock_count.sv
module hov_lock_count #(
  parameter int CNT_W = 8,
  parameter int TGT0  = 5,
  parameter int TGT1  = 16,
  parameter int TGT2  = 64,
  parameter int TGT3  = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_stb,
  input  logic       pfd_in_win,
  input  logic       dld_off,
  input  logic [1:0] sel,
  output logic       lock_q
);
  localparam logic [CNT_W-1:0] T0 = CNT_W'(TGT0);
  localparam logic [CNT_W-1:0] T1 = CNT_W'(TGT1);
  localparam logic [CNT_W-1:0] T2 = CNT_W'(TGT2);
  localparam logic [CNT_W-1:0] T3 = CNT_W'(TGT3);

  logic [CNT_W-1:0] cnt_q, cnt_d, tgt;
  logic             lock_d;

  always_comb begin
    unique case (sel)
      2'd0:    tgt = T0;
      2'd1:    tgt = T1;
      2'd2:    tgt = T2;
      default: tgt = T3;
    endcase
  end

  always_comb begin
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (dld_off) begin
      cnt_d  = '0;
      lock_d = 1'b0;
    end else if (pfd_stb) begin
      if (pfd_in_win) begin
        if (cnt_q < tgt) cnt_d = cnt_q + CNT_W'(1);
        lock_d = (cnt_d >= tgt);
      end else begin
        cnt_d  = '0;
        lock_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  // R3: a strobe outside the window drops lock on the next edge
  p_oow_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_stb && !pfd_in_win) |=> !lock_q);
  // R4: disabled detector keeps count and lock at zero
  p_dld_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dld_off |=> (!lock_q && cnt_q == '0));
  // R2: lock only rises on a strobe
  p_lock_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !pfd_stb) |=> !lock_q);
endmodule

// File: rtl/hov_pin_qual.sv
module hov_pin_qual #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic cmp_en,
  output logic pin_hi
);
  logic lvl_s;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_s = level;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-2:0], level};
      end
      assign lvl_s = sh_q[SYNC_STAGES-1];
    end
  endgenerate

  assign pin_hi = !cmp_en || lvl_s;
endmodule

// File: rtl/hov_seq.sv
module hov_seq
  import hov_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_ok,
  input  logic pin_hi,
  input  logic dld_off,
  input  logic hov_en,
  input  logic ext_mode,
  input  logic ext_req,
  input  logic sw_busy,
  input  logic ref_edge,
  output logic hov_q,
  output logic tri_q
);
  hov_state_e st_q, st_d;
  logic       brief_q, brief_d;
  logic       trig;

  always_comb begin
    trig = hov_en && (ext_mode ? ext_req : (!dld_off && !lock_ok));
  end

  always_comb begin
    st_d    = st_q;
    brief_d = brief_q;
    unique case (st_q)
      HS_REACQ: begin
        if (lock_ok && pin_hi) st_d = HS_LOCKED;
      end
      HS_LOCKED: begin
        if (trig) begin
          st_d    = HS_HOLD;
          brief_d = !ext_mode && sw_busy;
        end else if (!lock_ok) begin
          st_d = HS_REACQ;
        end
      end
      HS_HOLD: begin
        if (!hov_en) st_d = HS_REACQ;
        else if (ext_mode) begin
          if (!ext_req) st_d = HS_REACQ;
        end else if (ref_edge && (brief_q || !sw_busy)) begin
          st_d = HS_REACQ;
        end
      end
      default: st_d = HS_REACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= HS_REACQ;
      brief_q <= 1'b0;
      hov_q   <= 1'b0;
      tri_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      brief_q <= brief_d;
      hov_q   <= (st_d == HS_HOLD);
      tri_q   <= (st_d == HS_HOLD);
    end
  end

  // R9: holdover is only entered from the locked state
  p_hold_from_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_REACQ) |=> (st_q != HS_HOLD));
  // R6: master enable low forbids holdover
  p_enable_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hov_en |=> !hov_q);
  // R4: automatic holdover never starts with the detector disabled
  p_no_auto_dld_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_LOCKED && !ext_mode && dld_off) |=> (st_q != HS_HOLD));
  // R5: reacquire waits for lock and pin
  p_reacq_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_REACQ && !(lock_ok && pin_hi)) |=> (st_q == HS_REACQ));
  // R10: switchover holdover ends at the next reference edge
  p_brief_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == HS_HOLD && brief_q && hov_en && !ext_mode && ref_edge) |=> (st_q == HS_REACQ));
  // R11: tri-state request tracks holdover
  p_tri_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hov_q) |-> $rose(tri_q));
endmodule

// File: rtl/holdover_ctrl.sv
module holdover_ctrl #(
  parameter int CNT_W       = 8,
  parameter int TGT0        = 5,
  parameter int TGT1        = 16,
  parameter int TGT2        = 64,
  parameter int TGT3        = 255,
  parameter int SYNC_STAGES = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pfd_stb,
  input  logic       pfd_in_win,
  input  logic [1:0] ld_cnt_sel,
  input  logic       dld_off,
  input  logic       lkpin_level,
  input  logic       lkpin_cmp_en,
  input  logic       hov_en,
  input  logic       hov_ext_mode,
  input  logic       hov_ext_req,
  input  logic       sw_busy,
  input  logic       ref_edge_stb,
  output logic       lock_ok,
  output logic       hov_active,
  output logic       cp_tristate
);
  logic pin_hi;

  hov_lock_count #(
    .CNT_W(CNT_W), .TGT0(TGT0), .TGT1(TGT1), .TGT2(TGT2), .TGT3(TGT3)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfd_stb   (pfd_stb),
    .pfd_in_win(pfd_in_win),
    .dld_off   (dld_off),
    .sel       (ld_cnt_sel),
    .lock_q    (lock_ok)
  );

  hov_pin_qual #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .level (lkpin_level),
    .cmp_en(lkpin_cmp_en),
    .pin_hi(pin_hi)
  );

  hov_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_ok (lock_ok),
    .pin_hi  (pin_hi),
    .dld_off (dld_off),
    .hov_en  (hov_en),
    .ext_mode(hov_ext_mode),
    .ext_req (hov_ext_req),
    .sw_busy (sw_busy),
    .ref_edge(ref_edge_stb),
    .hov_q   (hov_active),
    .tri_q   (cp_tristate)
  );
endmodule

// File: tb/sim_holdover_ctrl.sv
module sim_holdover_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_stb = 0, pfd_in_win = 0, dld_off = 0, lkpin_level = 0, lkpin_cmp_en = 0;
  logic hov_en = 0, hov_ext_mode = 0, hov_ext_req = 0, sw_busy = 0, ref_edge_stb = 0;
  logic [1:0] ld_cnt_sel = 2'd0;
  logic lock_ok, hov_active, cp_tristate;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_cnt = 0, m_st = 0;
  bit m_lock = 0, m_brief = 0;

  always #2 clk = ~clk;

  holdover_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pfd_stb(pfd_stb), .pfd_in_win(pfd_in_win),
    .ld_cnt_sel(ld_cnt_sel), .dld_off(dld_off), .lkpin_level(lkpin_level),
    .lkpin_cmp_en(lkpin_cmp_en), .hov_en(hov_en), .hov_ext_mode(hov_ext_mode),
    .hov_ext_req(hov_ext_req), .sw_busy(sw_busy), .ref_edge_stb(ref_edge_stb),
    .lock_ok(lock_ok), .hov_active(hov_active), .cp_tristate(cp_tristate)
  );

  function automatic int tgt(input logic [1:0] s);
    case (s)
      2'd0: return 5;
      2'd1: return 16;
      2'd2: return 64;
      default: return 255;
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // cycle model built from R2..R10
  task automatic model_update();
    int  n_st;
    bit  n_brief, n_lock, pin, trig;
    if (!rst_n) begin
      m_cnt = 0; m_st = 0; m_lock = 0; m_brief = 0;
      return;
    end
    pin = !lkpin_cmp_en || lkpin_level;
    n_st = m_st; n_brief = m_brief;
    trig = hov_en && (hov_ext_mode ? hov_ext_req : (!dld_off && !m_lock));
    case (m_st)
      0: if (m_lock && pin) n_st = 1;
      1: if (trig) begin n_st = 2; n_brief = !hov_ext_mode && sw_busy; end
         else if (!m_lock) n_st = 0;
      default: begin
        if (!hov_en) n_st = 0;
        else if (hov_ext_mode) begin if (!hov_ext_req) n_st = 0; end
        else if (ref_edge_stb && (m_brief || !sw_busy)) n_st = 0;
      end
    endcase
    n_lock = m_lock;
    if (dld_off) begin m_cnt = 0; n_lock = 0; end
    else if (pfd_stb) begin
      if (pfd_in_win) begin
        if (m_cnt < tgt(ld_cnt_sel)) m_cnt++;
        n_lock = (m_cnt >= tgt(ld_cnt_sel));
      end else begin m_cnt = 0; n_lock = 0; end
    end
    m_lock = n_lock; m_st = n_st; m_brief = n_brief;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    #1;
    chk("R2 lock_ok vs model", lock_ok, m_lock);
    chk("R8 hov_active vs model", hov_active, m_st == 2);
    chk("R11 cp_tristate vs model", cp_tristate, m_st == 2);
  endtask

  task automatic strobes(input int n, input logic w);
    for (int i = 0; i < n; i++) begin
      pfd_stb = 1; pfd_in_win = w; cyc();
    end
    pfd_stb = 0; pfd_in_win = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk("R1 lock after reset", lock_ok, 1'b0);
    chk("R1 holdover after reset", hov_active, 1'b0);
    chk("R1 tristate after reset", cp_tristate, 1'b0);

    // R2: every count select
    for (int s = 0; s < 4; s++) begin
      ld_cnt_sel = 2'(s);
      strobes(1, 1'b0);
      strobes(tgt(2'(s)) - 1, 1'b1);
      chk("R2 lock low one short", lock_ok, 1'b0);
      strobes(1, 1'b1);
      chk("R2 lock at count", lock_ok, 1'b1);
    end
    ld_cnt_sel = 2'd0;
    cyc(); cyc();

    // R3 and R8: automatic holdover on lock loss
    hov_en = 1; hov_ext_mode = 0; sw_busy = 0;
    strobes(1, 1'b0);
    chk("R3 lock cleared", lock_ok, 1'b0);
    cyc();
    chk("R8 auto holdover", hov_active, 1'b1);
    chk("R11 tristate in holdover", cp_tristate, 1'b1);

    // R10: edge during switchover does not end a normal holdover
    sw_busy = 1; ref_edge_stb = 1; cyc(); ref_edge_stb = 0;
    chk("R10 normal holdover kept", hov_active, 1'b1);
    sw_busy = 0; ref_edge_stb = 1; cyc(); ref_edge_stb = 0;
    chk("R10 normal holdover ends", hov_active, 1'b0);

    // R9: no re-entry before relock
    hov_ext_mode = 1; hov_ext_req = 1;
    repeat (6) cyc();
    chk("R9 no holdover before relock", hov_active, 1'b0);
    strobes(5, 1'b1);
    chk("R9 lock regained", lock_ok, 1'b1);
    chk("R9 still no holdover", hov_active, 1'b0);
    cyc();
    chk("R9 locked not holding", hov_active, 1'b0);
    cyc();
    chk("R7 external holdover", hov_active, 1'b1);
    hov_ext_req = 0; cyc();
    chk("R7 external release", hov_active, 1'b0);

    // R6: master enable
    hov_en = 0; hov_ext_req = 1;
    repeat (5) cyc();
    chk("R6 suppressed", hov_active, 1'b0);
    hov_en = 1; cyc();
    chk("R6 enabled holdover", hov_active, 1'b1);
    hov_en = 0; cyc();
    chk("R6 drop ends holdover", hov_active, 1'b0);

    // R5: lock pin comparator
    lkpin_cmp_en = 1; lkpin_level = 0; hov_en = 1; hov_ext_req = 1;
    repeat (5) cyc();
    chk("R5 pin low blocks", hov_active, 1'b0);
    lkpin_level = 1; cyc(); cyc();
    chk("R5 pin high arms", hov_active, 1'b1);
    hov_ext_req = 0; cyc();
    lkpin_cmp_en = 0; lkpin_level = 0; hov_ext_req = 1;
    cyc(); cyc();
    chk("R5 comparator off reads high", hov_active, 1'b1);

    // R4: detector disabled
    hov_ext_req = 0; cyc(); cyc();
    hov_ext_mode = 0; dld_off = 1; cyc();
    chk("R4 lock forced low", lock_ok, 1'b0);
    repeat (8) cyc();
    chk("R4 no auto holdover", hov_active, 1'b0);
    dld_off = 0;

    // R10: switchover-triggered brief holdover
    strobes(5, 1'b1); cyc(); cyc();
    sw_busy = 1;
    strobes(1, 1'b0);
    cyc();
    chk("R10 brief holdover entered", hov_active, 1'b1);
    ref_edge_stb = 1; cyc(); ref_edge_stb = 0;
    chk("R10 brief holdover ends on edge", hov_active, 1'b0);
    sw_busy = 0;

    // random phase
    for (int i = 0; i < 6000; i++) begin
      pfd_stb      = ($urandom % 2) == 0;
      pfd_in_win   = ($urandom % 16) != 0;
      ref_edge_stb = ($urandom % 8) == 0;
      if (($urandom % 10) == 0) sw_busy = ~sw_busy;
      if (($urandom % 20) == 0) hov_ext_req = ~hov_ext_req;
      if (($urandom % 50) == 0) hov_ext_mode = ~hov_ext_mode;
      hov_en       = ($urandom % 25) != 0;
      dld_off      = ($urandom % 40) == 0;
      lkpin_cmp_en = ($urandom % 5) != 0;
      lkpin_level  = ($urandom % 10) != 0;
      if (($urandom % 60) == 0) ld_cnt_sel = 2'($urandom % 4);
      else if (($urandom % 30) == 0) ld_cnt_sel = 2'd0;
      cyc();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule